// File: doc/BRIEF.md
# Descriptor DMA Channel Control and Status Registers

This block is the register front end of one channel of a descriptor-driven DMA engine. Software reaches it over a simple 32-bit register bus whose data is in little-endian byte order. The block swaps each word into its internal order and keeps the channel status: run, pause, flush, wake, dead and active. It also holds the address of the next command descriptor.

Software changes status bits through a control register. The upper half of a control write is a mask, and only the status bits it selects take the value from the lower half. The block compares the run, wake and pause bits before and after the write. From that comparison it issues one single-cycle command to the sequencer: start, resume, pause or abort. The sequencer reports back over two inputs. One says the channel stopped, the other says it hit a fatal error.

Two enumerations form the control core. The access decoder sorts every bus cycle into one of these kinds: ACC_IDLE, ACC_CTRL_WR, ACC_CTRL_RD, ACC_STAT_WR, ACC_STAT_RD, ACC_PTR_WR or ACC_REJECT. The event register holds EV_NONE, EV_START, EV_RESUME, EV_PAUSE or EV_ABORT. Each control write loads the event register from the edge rules. Every cycle without a qualifying edge returns it to EV_NONE, so a command lasts exactly one cycle.

Top module: `dma_chan_regs`

## Requirements
- R1: Status bit positions are run=15, pause=14, flush=13, wake=12, dead=11 and active=10. The register offsets are control 0x00, status 0x04 and command pointer 0x0C. The bus word is byte-swapped (byte 0 becomes bits 31:24) before decode. On a control write, the swapped word's bits 31:16 form mask M and bits 15:0 form data D. The new status is (D & M & 0xF0FF) | (old & ~M), so bits 11:8 never come from D.
- R2: A read of the control offset returns 0.
- R3: A write to the status offset changes nothing. A read of it returns the byte-swapped form of {16'h0, status}.
- R4: A control write that changes run from 0 to 1 sets active. It pulses start unless R8 blocks it.
- R5: A control write that changes run from 1 to 0 clears active and dead and pulses abort.
- R6: A control write that leaves run unchanged but changes wake sets active. It pulses resume unless R8 blocks it.
- R7: A control write that leaves run and wake unchanged and raises pause clears active and pulses pause. Lowering pause gives no pulse.
- R8: When the resulting status has pause set, start and resume are not pulsed. Active is still set.
- R9: The flush bit always reads 0, even right after a write that sets it.
- R10: A write to the command pointer stores the byte-swapped word, but only when run and active are both 0. Otherwise the write is dropped.
- R11: Any access whose size is not 4 bytes is rejected. A rejected read returns 0 and a rejected write changes nothing.
- R12: At most one of the four command pulses is high in a cycle. Each lasts one cycle, in the cycle after the write.
- R13: seq_stop clears active. seq_fault sets dead and clears active. Both take effect at the same edge and on top of any control write in that cycle.
- R14: After reset, status, command pointer and all pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data, little-endian order |
| bus_rdata | output | 32 | Read data, combinational, little-endian order |
| seq_stop | input | 1 | Sequencer stopped: clear active |
| seq_fault | input | 1 | Sequencer fatal error: set dead, clear active |
| start_pulse | output | 1 | Start command to sequencer |
| resume_pulse | output | 1 | Resume command to sequencer |
| pause_pulse | output | 1 | Pause command to sequencer |
| abort_pulse | output | 1 | Abort command to sequencer |
| chan_status | output | 16 | Current channel status |
| cmd_ptr | output | 32 | Command descriptor pointer |

## Verification
A control write and a sequencer fault can reach the active and dead bits in the same clock edge. The bench provokes this by toggling wake in the same cycle that seq_fault is raised. It then checks that resume is still pulsed while the stored status shows dead set and active clear, which shows the fault was layered over the write's outcome. It also lowers run on a faulted channel and checks that the abort path clears dead again.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int RUN_B    = 15;
    localparam int PAUSE_B  = 14;
    localparam int FLUSH_B  = 13;
    localparam int WAKE_B   = 12;
    localparam int DEAD_B   = 11;
    localparam int ACTIVE_B = 10;
    localparam int STAT_W   = 16;
    localparam int WORD_W   = 32;
    localparam logic [STAT_W-1:0] DATA_KEEP = 16'hF0FF;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_CTRL_WR,
        ACC_CTRL_RD,
        ACC_STAT_WR,
        ACC_STAT_RD,
        ACC_PTR_WR,
        ACC_REJECT
    } acc_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_START,
        EV_RESUME,
        EV_PAUSE,
        EV_ABORT
    } ev_e;

    function automatic logic [WORD_W-1:0] swap32(input logic [WORD_W-1:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
    import dcr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int SIZE_W     = 3,
    parameter int WORD_BYTES = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h00,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h04,
    parameter logic [ADDR_W-1:0] PTR_OFS  = 8'h0C
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output acc_e              kind
);

    localparam logic [SIZE_W-1:0] FULL_SIZE = SIZE_W'(WORD_BYTES);

    always_comb begin
        kind = ACC_IDLE;
        if (valid) begin
            if (size != FULL_SIZE) begin
                kind = ACC_REJECT;
            end else if (addr == CTRL_OFS) begin
                kind = write ? ACC_CTRL_WR : ACC_CTRL_RD;
            end else if (addr == STAT_OFS) begin
                kind = write ? ACC_STAT_WR : ACC_STAT_RD;
            end else if (addr == PTR_OFS && write) begin
                kind = ACC_PTR_WR;
            end
        end
    end

endmodule

// File: rtl/dcr_ctrl_update.sv
module dcr_ctrl_update
    import dcr_pkg::*;
(
    input  logic [STAT_W-1:0] old_stat,
    input  logic [WORD_W-1:0] ctrl_word,
    output logic [STAT_W-1:0] new_stat,
    output ev_e               event_o
);

    logic [STAT_W-1:0] mask;
    logic [STAT_W-1:0] data;
    logic [STAT_W-1:0] merged;

    assign mask   = ctrl_word[WORD_W-1:STAT_W];
    assign data   = ctrl_word[STAT_W-1:0];
    assign merged = (data & mask & DATA_KEEP) | (old_stat & ~mask);

    always_comb begin
        new_stat = merged;
        event_o  = EV_NONE;
        if (merged[RUN_B] != old_stat[RUN_B]) begin
            if (merged[RUN_B]) begin
                new_stat[ACTIVE_B] = 1'b1;
                event_o = merged[PAUSE_B] ? EV_NONE : EV_START;
            end else begin
                new_stat[ACTIVE_B] = 1'b0;
                new_stat[DEAD_B]   = 1'b0;
                event_o = EV_ABORT;
            end
        end else if (merged[WAKE_B] != old_stat[WAKE_B]) begin
            new_stat[ACTIVE_B] = 1'b1;
            event_o = merged[PAUSE_B] ? EV_NONE : EV_RESUME;
        end else if (merged[PAUSE_B] && !old_stat[PAUSE_B]) begin
            new_stat[ACTIVE_B] = 1'b0;
            event_o = EV_PAUSE;
        end
        new_stat[FLUSH_B] = 1'b0;
    end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dcr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int WORD_BYTES = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h00,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h04,
    parameter logic [ADDR_W-1:0] PTR_OFS  = 8'h0C,
    localparam int SIZE_W = $clog2(WORD_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              seq_stop,
    input  logic              seq_fault,
    output logic              start_pulse,
    output logic              resume_pulse,
    output logic              pause_pulse,
    output logic              abort_pulse,
    output logic [15:0]       chan_status,
    output logic [31:0]       cmd_ptr
);

    acc_e              kind;
    ev_e               ev_q, ev_d;
    ev_e               ctrl_ev;
    logic [STAT_W-1:0] stat_q, stat_d, ctrl_stat;
    logic [WORD_W-1:0] ptr_q, ptr_d;
    logic [WORD_W-1:0] wword;

    assign wword = swap32(bus_wdata);

    dcr_decode #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WORD_BYTES(WORD_BYTES),
        .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS), .PTR_OFS(PTR_OFS)
    ) u_dec (
        .valid(bus_valid), .write(bus_write), .addr(bus_addr),
        .size(bus_size), .kind(kind)
    );

    dcr_ctrl_update u_upd (
        .old_stat(stat_q), .ctrl_word(wword),
        .new_stat(ctrl_stat), .event_o(ctrl_ev)
    );

    // next-state selection from the decoded access kind
    always_comb begin
        stat_d = stat_q;
        ptr_d  = ptr_q;
        ev_d   = EV_NONE;
        unique case (kind)
            ACC_CTRL_WR: begin
                stat_d = ctrl_stat;
                ev_d   = ctrl_ev;
            end
            ACC_PTR_WR: begin
                if (!stat_q[RUN_B] && !stat_q[ACTIVE_B]) ptr_d = wword;
            end
            ACC_IDLE, ACC_CTRL_RD, ACC_STAT_WR, ACC_STAT_RD, ACC_REJECT: begin
            end
            default: begin
            end
        endcase
        // sequencer reports land on top of the bus outcome
        if (seq_fault) begin
            stat_d[DEAD_B]   = 1'b1;
            stat_d[ACTIVE_B] = 1'b0;
        end else if (seq_stop) begin
            stat_d[ACTIVE_B] = 1'b0;
        end
    end

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            ptr_q  <= '0;
            ev_q   <= EV_NONE;
        end else begin
            stat_q <= stat_d;
            ptr_q  <= ptr_d;
            ev_q   <= ev_d;
        end
    end

    // outputs
    always_comb begin
        start_pulse  = 1'b0;
        resume_pulse = 1'b0;
        pause_pulse  = 1'b0;
        abort_pulse  = 1'b0;
        unique case (ev_q)
            EV_START:  start_pulse  = 1'b1;
            EV_RESUME: resume_pulse = 1'b1;
            EV_PAUSE:  pause_pulse  = 1'b1;
            EV_ABORT:  abort_pulse  = 1'b1;
            EV_NONE:   begin end
            default:   begin end
        endcase
        bus_rdata = '0;
        if (kind == ACC_STAT_RD) bus_rdata = swap32({16'h0, stat_q});
    end

    assign chan_status = stat_q;
    assign cmd_ptr     = ptr_q;

endmodule

// File: rtl/dcr_chk.sv
module dcr_chk #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              seq_fault,
    input logic              start_pulse,
    input logic              resume_pulse,
    input logic              pause_pulse,
    input logic              abort_pulse,
    input logic [15:0]       chan_status,
    input logic [31:0]       cmd_ptr
);

    a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({start_pulse, resume_pulse, pause_pulse, abort_pulse}) <= 1);

    a_r4_start_active: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && !$past(seq_fault)) |-> chan_status[10]);

    a_r5_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_pulse && !$past(seq_fault)) |-> (!chan_status[15] && !chan_status[10] && !chan_status[11]));

    a_r7_pause_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        pause_pulse |-> (chan_status[14] && !chan_status[10]));

    a_r9_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_status[13]);

    a_r10_ptr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_status[15] || chan_status[10]) |=> $stable(cmd_ptr));

    a_r2_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == CTRL_OFS) |-> bus_rdata == 32'h0);

    a_r8_no_start_paused: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse || resume_pulse) |-> !chan_status[14]);

endmodule

bind dma_chan_regs dcr_chk #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_chk (.*);

// File: tb/dma_chan_regs_tb_top.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        seq_stop = 1'b0, seq_fault = 1'b0;
    logic        start_pulse, resume_pulse, pause_pulse, abort_pulse;
    logic [15:0] chan_status;
    logic [31:0] cmd_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] st;
        logic [31:0] ptr;
        logic [3:0]  pl;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [15:0] m_st = '0;
    logic [31:0] m_ptr = '0;

    always #2 clk = ~clk;

    dma_chan_regs dut_i (.*);

    function automatic logic [31:0] sw(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference behaviour derived from the requirements
    task automatic model(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] wd,
                         input logic stp, input logic flt, output logic [3:0] pl);
        logic [31:0] v;
        logic [15:0] m, d, ns;
        pl = 4'b0;
        v  = sw(wd);
        if (sz == 3'd4 && a == 8'h00) begin
            m  = v[31:16];
            d  = v[15:0];
            ns = (d & m & 16'hF0FF) | (m_st & ~m);
            if (ns[15] != m_st[15]) begin
                if (ns[15]) begin ns[10] = 1'b1; if (!ns[14]) pl = 4'b1000; end
                else begin ns[10] = 1'b0; ns[11] = 1'b0; pl = 4'b0001; end
            end else if (ns[12] != m_st[12]) begin
                ns[10] = 1'b1; if (!ns[14]) pl = 4'b0100;
            end else if (ns[14] && !m_st[14]) begin
                ns[10] = 1'b0; pl = 4'b0010;
            end
            ns[13] = 1'b0;
            m_st = ns;
        end else if (sz == 3'd4 && a == 8'h0C && !m_st[15] && !m_st[10]) begin
            m_ptr = v;
        end
        if (flt) begin m_st[11] = 1'b1; m_st[10] = 1'b0; end
        else if (stp) m_st[10] = 1'b0;
    endtask

    // driver: one bus write plus optional sequencer reports
    task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] wd,
                      input logic stp, input logic flt, input string tag);
        exp_t e;
        logic [3:0] pl;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = wd;
        seq_stop = stp; seq_fault = flt;
        @(posedge clk);
        #1;
        bus_valid = 1'b0; seq_stop = 1'b0; seq_fault = 1'b0;
        model(a, sz, wd, stp, flt, pl);
        e.st = m_st; e.ptr = m_ptr; e.pl = pl; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic ctl(input logic [15:0] m, input logic [15:0] d, input string tag);
        wr(8'h00, 3'd4, sw({m, d}), 1'b0, 1'b0, tag);
    endtask

    task automatic rd(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        check(tag, bus_rdata, exp);
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
        e.st = m_st; e.ptr = m_ptr; e.pl = 4'b0; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares design state one cycle after each access
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " status"}, {16'h0, chan_status}, {16'h0, e.st});
            check({e.tag, " ptr"}, cmd_ptr, e.ptr);
            check({e.tag, " pulses"}, {28'h0, start_pulse, resume_pulse, pause_pulse, abort_pulse},
                  {28'h0, e.pl});
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R14 status reset", {16'h0, chan_status}, 32'h0);
        check("R14 ptr reset", cmd_ptr, 32'h0);
        check("R14 pulses reset", {28'h0, start_pulse, resume_pulse, pause_pulse, abort_pulse}, 32'h0);
        rst_n = 1'b1;

        wr(8'h0C, 3'd4, 32'h78563412, 1'b0, 1'b0, "R10 ptr write idle");
        ctl(16'h8000, 16'h8000, "R4 run rise start");
        rd(8'h00, 3'd4, 32'h0, "R2 ctrl read");
        rd(8'h04, 3'd4, sw({16'h0, 16'h8400}), "R3 status read swapped");
        wr(8'h04, 3'd4, 32'hFFFFFFFF, 1'b0, 1'b0, "R3 status write ignored");
        wr(8'h0C, 3'd4, 32'hAABBCCDD, 1'b0, 1'b0, "R10 ptr write dropped running");
        ctl(16'h1000, 16'h1000, "R6 wake resume");
        ctl(16'h4000, 16'h4000, "R7 pause rise");
        ctl(16'h1000, 16'h0000, "R8 wake while paused");
        ctl(16'h2000, 16'h2000, "R9 flush self clear");
        ctl(16'h0FFF, 16'h0F5A, "R1 masked low bits");
        ctl(16'h4000, 16'h0000, "R7 pause fall no pulse");
        wr(8'h00, 3'd4, sw({16'h1000, 16'h1000}), 1'b0, 1'b1, "R13 fault with resume");
        rd(8'h04, 3'd4, sw({16'h0, m_st}), "R3 status read after fault");
        ctl(16'h8000, 16'h0000, "R5 run fall abort");
        wr(8'h0C, 3'd2, 32'h11111111, 1'b0, 1'b0, "R11 short write dropped");
        rd(8'h04, 3'd2, 32'h0, "R11 short read zero");
        wr(8'h00, 3'd1, sw({16'h8000, 16'h8000}), 1'b0, 1'b0, "R11 short ctrl ignored");
        wr(8'h0C, 3'd4, 32'h00100000, 1'b0, 1'b0, "R10 ptr write after abort");
        ctl(16'h4000, 16'h4000, "R7 pause while stopped");
        ctl(16'h8000, 16'h8000, "R8 run rise paused no start");
        wr(8'h08, 3'd4, 32'h0, 1'b1, 1'b0, "R13 seq stop");
        wr(8'h0C, 3'd4, 32'h01020304, 1'b0, 1'b0, "R10 ptr dropped run only");
        ctl(16'hC000, 16'h8000, "R12 pause drop no pulse");
        ctl(16'h8000, 16'h0000, "R12 abort single");
        repeat (3) @(negedge clk);
        check("R12 pulse one cycle", {28'h0, start_pulse, resume_pulse, pause_pulse, abort_pulse}, 32'h0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule